// File: doc/BRIEF.md
# Multi-Cycle Transaction Lock Sequencer

This block turns one logical memory transfer into the sequence of bus cycles that a narrow or resizable data bus needs. A requester offers a 32-bit, 64-bit or 128-bit line-fill transfer with a start address and a direction. The sequencer then runs one bus cycle after another. Each cycle has one address-strobe clock, followed by data clocks that last until a ready strobe returns. For every cycle it drives the byte address and the active-low byte-lane enables.

Two indicators frame the sequence. The active-low lock output marks a transfer that still has bus cycles to run, so outside logic does not split it. The active-low final output marks the cycle that closes the transfer. These two normally mirror each other. The exception is the opening cycle of a 64-bit write, where both are asserted.

The bus width and the cache-enable input are captured in the clock that accepts the request. They fix the cycle count and the address step for the whole transfer.

Top module: `txn_lock_seq`

## Requirements
- R1: After reset, and whenever no transfer is in progress, `req_ready_o` is 1, and `addr_strobe_n_o`, `final_n_o`, `xlock_n_o` and all four bits of `byte_en_n_o` are 1.
- R2: A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both 1. The size code is 0 for 32 bits (4 bytes), 1 for 64 bits (8 bytes) and 2 for a line fill. The bus width is 8 bits when `bus8_n_i` is 0; otherwise it is 16 bits when `bus16_n_i` is 0; otherwise it is 32 bits. The transfer runs exactly (bytes / bus-width bytes) bus cycles.
- R3: The first cycle address is the request address with its low log2(bytes) bits cleared. Each later cycle adds the bus width in bytes. `byte_en_n_o` bit k is 0 when byte lane k is used. On a 32-bit bus all four lanes are used. On a 16-bit bus the lanes are {1,0} when address bit 1 is 0, and {3,2} when it is 1. On an 8-bit bus only the lane equal to address bits [1:0] is used.
- R4: A line-fill read with `cache_en_n_i` at 0 when accepted moves 16 bytes. If `cache_en_n_i` is 1, or if `req_write_i` is 1, it moves 4 bytes instead.
- R5: `xlock_n_o` is 0 during every bus cycle of a transfer except the final one. It is 1 during the final cycle, and so stays 1 throughout a single-cycle transfer.
- R6: `final_n_o` is 0 during the final bus cycle. Outside the case in R7, `final_n_o` is the inverse of `xlock_n_o` in every bus cycle.
- R7: During the first bus cycle of a 64-bit write, `final_n_o` and `xlock_n_o` are both 0.
- R8: A bus cycle has one clock with `addr_strobe_n_o` at 0, then data clocks until a ready strobe is sampled. The next cycle's address strobe follows in the clock right after that ready. A ready strobe in the address-strobe clock is ignored. A transfer of n cycles with w wait clocks per cycle therefore keeps `req_ready_o` at 0 for n*(2+w) clocks.
- R9: Ready strobes while no transfer is in progress are ignored.
- R10: Either `ready_n_i` or `burst_ready_n_i` at 0 completes the current data clock.
- R11: Address, byte enables, `final_n_o` and `xlock_n_o` hold steady from a cycle's address strobe until its ready strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Transfer request offered |
| req_ready_o | output | 1 | Sequencer idle, request can be taken |
| req_size_i | input | 2 | Size code: 0 = 32-bit, 1 = 64-bit, 2 = line fill |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Transfer start byte address |
| bus8_n_i | input | 1 | Active low: bus is 8 bits wide |
| bus16_n_i | input | 1 | Active low: bus is 16 bits wide |
| cache_en_n_i | input | 1 | Active low: line fill may be cached |
| ready_n_i | input | 1 | Active-low single-cycle ready |
| burst_ready_n_i | input | 1 | Active-low burst ready |
| addr_strobe_n_o | output | 1 | Active-low address strobe, one clock per bus cycle |
| cyc_addr_o | output | ADDR_W | Byte address of the current bus cycle |
| byte_en_n_o | output | 4 | Active-low byte-lane enables |
| final_n_o | output | 1 | Active low: this cycle closes the transfer |
| xlock_n_o | output | 1 | Active low: more cycles of this transfer follow |

## Verification
One case to provoke is a ready strobe in the same clock as a cycle's address strobe. The bench drives ready during the address-strobe clock and then holds off the real ready for some wait clocks. It checks that no early strobe or early idle appears, by comparing the measured busy time with n*(2+w). The other coincidence is the 64-bit write, where the final indication and the lock indication both fall in the first cycle. The scoreboard compares both pins in that cycle and again in the next, where they separate.

// File: rtl/txn_lock_pkg.sv
package txn_lock_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    localparam logic [1:0] SZ_32   = 2'd0;
    localparam logic [1:0] SZ_64   = 2'd1;
    localparam logic [1:0] SZ_LINE = 2'd2;

    // log2 of bus width in bytes
    localparam logic [1:0] WL_8  = 2'd0;
    localparam logic [1:0] WL_16 = 2'd1;
    localparam logic [1:0] WL_32 = 2'd2;

endpackage

// File: rtl/txn_lock_plan.sv
module txn_lock_plan
    import txn_lock_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LINE_LOG = 4,
    parameter int CNT_W    = LINE_LOG + 1
) (
    input  logic [1:0]        size_i,
    input  logic              write_i,
    input  logic              bus8_n_i,
    input  logic              bus16_n_i,
    input  logic              cache_en_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [1:0]        wlog_o,
    output logic [CNT_W-1:0]  count_o,
    output logic [ADDR_W-1:0] base_o
);

    logic [3:0] bytes_log;

    always_comb begin
        case (size_i)
            SZ_64:   bytes_log = 4'd3;
            SZ_LINE: bytes_log = (!write_i && !cache_en_n_i) ? 4'(LINE_LOG) : 4'd2;
            default: bytes_log = 4'd2;
        endcase

        if (!bus8_n_i)       wlog_o = WL_8;
        else if (!bus16_n_i) wlog_o = WL_16;
        else                 wlog_o = WL_32;

        count_o = CNT_W'(1) << (bytes_log - {2'b00, wlog_o});
        base_o  = addr_i & ~((ADDR_W'(1) << bytes_log) - ADDR_W'(1));
    end

endmodule

// File: rtl/txn_lock_lanes.sv
module txn_lock_lanes
    import txn_lock_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       active_i,
    input  logic [1:0] wlog_i,
    input  logic [1:0] low_i,
    output logic [3:0] be_n_o
);

    for (genvar l = 0; l < 4; l++) begin : g_lane
        logic on;
        always_comb begin
            case (wlog_i)
                WL_8:    on = (low_i == 2'(l));
                WL_16:   on = (low_i[1] == l[1]);
                default: on = 1'b1;
            endcase
        end
        assign be_n_o[l] = !(active_i && on);
    end

    AST_BYTE_LANE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active_i && wlog_i == WL_8) |-> ($countones(~be_n_o) == 1)); // R3

endmodule

// File: rtl/txn_lock_seq.sv
module txn_lock_seq
    import txn_lock_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LINE_LOG = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [1:0]        req_size_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              bus8_n_i,
    input  logic              bus16_n_i,
    input  logic              cache_en_n_i,
    input  logic              ready_n_i,
    input  logic              burst_ready_n_i,
    output logic              addr_strobe_n_o,
    output logic [ADDR_W-1:0] cyc_addr_o,
    output logic [3:0]        byte_en_n_o,
    output logic              final_n_o,
    output logic              xlock_n_o
);

    localparam int CNT_W = LINE_LOG + 1;

    typedef struct packed {
        phase_e              phase;
        logic [ADDR_W-1:0]   addr;
        logic [CNT_W-1:0]    rem;
        logic [1:0]          wlog;
        logic                first;
        logic                wr64;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic [1:0]        plan_wlog;
    logic [CNT_W-1:0]  plan_count;
    logic [ADDR_W-1:0] plan_base;
    logic              cyc_ready;
    logic              active;
    logic              last_cyc;

    txn_lock_plan #(
        .ADDR_W   (ADDR_W),
        .LINE_LOG (LINE_LOG),
        .CNT_W    (CNT_W)
    ) plan_i (
        .size_i       (req_size_i),
        .write_i      (req_write_i),
        .bus8_n_i     (bus8_n_i),
        .bus16_n_i    (bus16_n_i),
        .cache_en_n_i (cache_en_n_i),
        .addr_i       (req_addr_i),
        .wlog_o       (plan_wlog),
        .count_o      (plan_count),
        .base_o       (plan_base)
    );

    assign cyc_ready = !ready_n_i || !burst_ready_n_i;

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_IDLE: begin
                if (req_valid_i) begin
                    st_d.phase = PH_ADDR;
                    st_d.addr  = plan_base;
                    st_d.rem   = plan_count;
                    st_d.wlog  = plan_wlog;
                    st_d.first = 1'b1;
                    st_d.wr64  = (req_size_i == SZ_64) && req_write_i;
                end
            end
            PH_ADDR: begin
                st_d.phase = PH_DATA;
            end
            PH_DATA: begin
                if (cyc_ready) begin
                    st_d.first = 1'b0;
                    if (st_q.rem == CNT_W'(1)) begin
                        st_d.phase = PH_IDLE;
                        st_d.wr64  = 1'b0;
                    end else begin
                        st_d.phase = PH_ADDR;
                        st_d.addr  = st_q.addr + (ADDR_W'(1) << st_q.wlog);
                        st_d.rem   = st_q.rem - CNT_W'(1);
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.phase <= PH_IDLE;
            st_q.addr  <= '0;
            st_q.rem   <= '0;
            st_q.wlog  <= WL_32;
            st_q.first <= 1'b0;
            st_q.wr64  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active          = (st_q.phase != PH_IDLE);
    assign last_cyc        = (st_q.rem == CNT_W'(1));
    assign req_ready_o     = !active;
    assign addr_strobe_n_o = !(st_q.phase == PH_ADDR);
    assign cyc_addr_o      = st_q.addr;
    assign final_n_o       = !(active && (last_cyc || (st_q.wr64 && st_q.first)));
    assign xlock_n_o       = !(active && !last_cyc);

    txn_lock_lanes lanes_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .active_i (active),
        .wlog_i   (st_q.wlog),
        .low_i    (st_q.addr[1:0]),
        .be_n_o   (byte_en_n_o)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_ready_o |-> (addr_strobe_n_o && final_n_o && xlock_n_o && byte_en_n_o == 4'hF)); // R1

    AST_ADDR_ONE_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !addr_strobe_n_o |=> (addr_strobe_n_o && !req_ready_o)); // R8

    AST_WAIT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.phase == PH_DATA && !cyc_ready) |=> ($stable(cyc_addr_o) && $stable(byte_en_n_o)
            && $stable(final_n_o) && $stable(xlock_n_o))); // R11

    AST_LOCK_TO_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.phase == PH_DATA && cyc_ready && !xlock_n_o) |=> !addr_strobe_n_o); // R5

    AST_FINAL_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.phase == PH_DATA && cyc_ready && xlock_n_o) |=> req_ready_o); // R6

    AST_IDLE_READY_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_ready_o && !req_valid_i) |=> req_ready_o); // R9

    AST_WR64_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!req_ready_o && st_q.wr64 && st_q.first) |-> (!final_n_o && !xlock_n_o)); // R7

    AST_INVERSE_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!req_ready_o && !(st_q.wr64 && st_q.first)) |-> (final_n_o != xlock_n_o)); // R6

endmodule

// File: tb/txn_lock_seq_tb_top.sv
module txn_lock_seq_tb_top;

    typedef struct {
        logic [31:0] a;
        logic [3:0]  be;
        logic        fin;
        logic        lck;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_size = 2'd0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic        bus8_n = 1'b1;
    logic        bus16_n = 1'b1;
    logic        cache_en_n = 1'b1;
    logic        rdy_n = 1'b1;
    logic        brdy_n = 1'b1;
    logic        ads_n;
    logic [31:0] cyc_addr;
    logic [3:0]  be_n;
    logic        fin_n;
    logic        lock_n;

    int   errors = 0;
    int   checks = 0;
    int   waits = 0;
    bit   glitch = 1'b0;
    bit   use_burst = 1'b0;
    bit   idle_poke = 1'b0;
    int   cyc_cnt = 0;
    exp_t expq[$];
    exp_t cur;
    bit   in_cyc = 1'b0;

    always #10 clk = ~clk;

    txn_lock_seq dut_i (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .req_valid_i     (req_valid),
        .req_ready_o     (req_ready),
        .req_size_i      (req_size),
        .req_write_i     (req_write),
        .req_addr_i      (req_addr),
        .bus8_n_i        (bus8_n),
        .bus16_n_i       (bus16_n),
        .cache_en_n_i    (cache_en_n),
        .ready_n_i       (rdy_n),
        .burst_ready_n_i (brdy_n),
        .addr_strobe_n_o (ads_n),
        .cyc_addr_o      (cyc_addr),
        .byte_en_n_o     (be_n),
        .final_n_o       (fin_n),
        .xlock_n_o       (lock_n)
    );

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // ready responder
    initial begin
        forever begin
            @(negedge clk);
            rdy_n  = !(idle_poke && ads_n);
            brdy_n = 1'b1;
            if (!ads_n) begin
                rdy_n = !glitch;
                repeat (waits) begin
                    @(negedge clk);
                    rdy_n = 1'b1;
                end
                @(negedge clk);
                if (use_burst) brdy_n = 1'b0;
                else           rdy_n  = 1'b0;
            end
        end
    end

    // monitor: pops expected items at each address strobe
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !ads_n) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R2 unexpected address strobe", 64'(cyc_addr), 64'd0);
                end else begin
                    cur = expq.pop_front();
                    in_cyc = 1'b1;
                    check(cyc_addr == cur.a, "R3 cycle address", 64'(cyc_addr), 64'(cur.a));
                    check(be_n == cur.be, "R3 byte enables", 64'(be_n), 64'(cur.be));
                    check(lock_n == cur.lck, "R5/R7 lock output", 64'(lock_n), 64'(cur.lck));
                    check(fin_n == cur.fin, "R6/R7 final output", 64'(fin_n), 64'(cur.fin));
                end
            end else if (rst_n && in_cyc && !req_ready) begin
                check(cyc_addr == cur.a && be_n == cur.be && lock_n == cur.lck && fin_n == cur.fin,
                      "R11 outputs held in wait", {cyc_addr, be_n, lock_n, fin_n},
                      {cur.a, cur.be, cur.lck, cur.fin});
            end else if (req_ready) begin
                in_cyc = 1'b0;
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 50000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected<50000", cyc_cnt);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic issue(input logic [1:0] sz, input bit wr, input logic [31:0] ad,
                         input bit b8n, input bit b16n, input bit kn,
                         input int w, input bit gl, input bit bu);
        int bytes;
        int wb;
        int n;
        int busy;
        logic [31:0] base;
        while (!req_ready) @(negedge clk);
        bytes = (sz == 2'd1) ? 8 : (sz == 2'd2 && !wr && !kn) ? 16 : 4;
        wb    = !b8n ? 1 : !b16n ? 2 : 4;
        n     = bytes / wb;
        base  = ad & ~(32'(bytes) - 32'd1);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.a = base + 32'(i * wb);
            if (wb == 4)      e.be = 4'b0000;
            else if (wb == 2) e.be = e.a[1] ? 4'b0011 : 4'b1100;
            else              e.be = ~(4'b0001 << e.a[1:0]);
            e.lck = (i == n - 1);
            e.fin = !((i == n - 1) || (sz == 2'd1 && wr && i == 0));
            expq.push_back(e);
        end
        waits = w; glitch = gl; use_burst = bu;
        req_size = sz; req_write = wr; req_addr = ad;
        bus8_n = b8n; bus16_n = b16n; cache_en_n = kn;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        bus8_n = 1'b1; bus16_n = 1'b1; cache_en_n = 1'b1;
        busy = 0;
        while (!req_ready) begin
            busy++;
            @(negedge clk);
        end
        check(busy == n * (2 + w), "R8 busy clocks", 64'(busy), 64'(n * (2 + w)));
        check(expq.size() == 0, "R2 cycle count", 64'(expq.size()), 64'd0);
        expq.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready && ads_n && fin_n && lock_n && be_n == 4'hF, "R1 idle outputs",
              {req_ready, ads_n, fin_n, lock_n, be_n}, 8'hFF);

        issue(2'd0, 1'b0, 32'h0000_1007, 1'b1, 1'b1, 1'b1, 0, 1'b0, 1'b0); // R2 single 32-bit
        issue(2'd1, 1'b0, 32'h0000_200C, 1'b1, 1'b1, 1'b1, 1, 1'b0, 1'b0); // R5 R6 64-bit read
        issue(2'd1, 1'b1, 32'h0000_3008, 1'b1, 1'b1, 1'b1, 0, 1'b0, 1'b0); // R7 64-bit write
        issue(2'd2, 1'b0, 32'h0000_4024, 1'b1, 1'b1, 1'b0, 1, 1'b0, 1'b1); // R4 R10 line fill burst
        issue(2'd2, 1'b0, 32'h0000_5038, 1'b1, 1'b1, 1'b1, 0, 1'b0, 1'b0); // R4 fallback, no cache
        issue(2'd2, 1'b1, 32'h0000_6004, 1'b1, 1'b1, 1'b0, 0, 1'b0, 1'b0); // R4 fallback, write
        issue(2'd1, 1'b0, 32'h0000_7000, 1'b1, 1'b0, 1'b1, 0, 1'b0, 1'b1); // R3 16-bit bus
        issue(2'd0, 1'b1, 32'h0000_8000, 1'b0, 1'b1, 1'b1, 2, 1'b1, 1'b0); // R8 ready in strobe clock
        issue(2'd2, 1'b0, 32'h0000_9010, 1'b0, 1'b0, 1'b0, 0, 1'b1, 1'b1); // R3 8-bit line fill
        issue(2'd1, 1'b1, 32'h0000_A008, 1'b1, 1'b0, 1'b1, 1, 1'b0, 1'b0); // R7 64-bit write on 16-bit

        // R9 ready strobes while idle are ignored
        idle_poke = 1'b1;
        repeat (4) begin
            @(negedge clk);
            check(req_ready && ads_n && lock_n && fin_n, "R9 idle ready ignored",
                  {req_ready, ads_n, lock_n, fin_n}, 4'hF);
        end
        idle_poke = 1'b0;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule